// File: doc/BRIEF.md
# Shifted Register Operand Unit

This unit builds the second operand of a 32-bit data-processing instruction from a register value. It decodes a 12-bit operand field that names the source register, the kind of shift and where the shift amount comes from. It then applies one of four shifts to the register value: logical left, logical right, arithmetic right, or rotate right, where rotate right also covers rotate-through-carry. It produces the 32-bit operand together with the shifter's carry-out.

The register file, the ALU and the flag register live outside the block. The caller reads the register file and hands over two values: the value of the source register (`rm_val`) and the value of the amount register (`rs_val`). It also supplies the address of the current instruction, the present carry flag and a set-flags request. The block registers its result one cycle after a valid strobe. Alongside the result it gives a carry value and a one-bit request telling the flag register whether to take that carry.

Top module: `shift_operand_unit`

## Requirements
- R1: A result appears on the outputs with `out_valid` high exactly one cycle after `in_valid` is sampled high. `out_valid` is low in every cycle that does not follow an accepted request.
- R2: When `op_field[3:0]` is 15, the value that is shifted is `instr_addr + 8` and `rm_val` is ignored.
- R3: Field layout: bit 4 set selects a register amount, otherwise the amount is the immediate `op_field[11:7]`. `op_field[6:5]` selects the kind: 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR. For LSL by immediate 0, the operand is the input unchanged and the carry is not affected. For LSL by immediate n (1..31), the result is the input shifted left by n and carry is input bit 32−n.
- R4: An immediate amount of 0 with LSR or ASR means a shift by 32. LSR gives 0 and ASR gives 32 copies of bit 31; in both cases carry is bit 31. For immediate n (1..31), LSR and ASR give carry equal to input bit n−1.
- R5: ROR with immediate 0 is a one-bit rotate through carry. The result is {carry_in, input[31:1]} and carry is input bit 0. ROR by immediate n (1..31) rotates by n and gives carry equal to input bit n−1.
- R6: With a register amount whose low 8 bits are 0, the operand equals the input for every shift kind, and the carry is not affected.
- R7: With a register amount a, LSL and LSR give 0 for a ≥ 32. Carry for a = 32 is bit 0 for LSL and bit 31 for LSR. Carry for a > 32 is 0. For a in 1..31, carry is bit 32−a for LSL and bit a−1 for LSR.
- R8: A register-amount ASR with a ≥ 32 gives 32 copies of bit 31, with carry equal to bit 31.
- R9: A register-amount ROR rotates by a mod 32 and gives carry equal to input bit (a−1) mod 32.
- R10: `carry_upd` is high only when `set_flags` was high and the shift affects the carry. Whenever the carry is not affected, `carry_out` equals the incoming `carry_in`.
- R11: Only the low 8 bits of `rs_val` form a register amount; bits 31..8 have no effect.
- R12: While `rst_n` is low at a clock edge, `out_valid` and `carry_upd` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_field | input | 12 | Operand field: source register, shift kind, amount source and amount |
| rm_val | input | 32 | Value read for the source register |
| rs_val | input | 32 | Value read for the amount register |
| instr_addr | input | 32 | Address of the current instruction |
| carry_in | input | 1 | Present carry flag |
| set_flags | input | 1 | Instruction requests a flag update |
| out_valid | output | 1 | Result valid |
| operand | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry, or `carry_in` when the carry is not affected |
| carry_upd | output | 1 | Flag register should take `carry_out` |

## Verification
The assertions check four behaviours on every cycle: the one-cycle valid latency, the zero-register-amount pass-through with the carry held, the zero result with zero carry of LSL/LSR beyond 32, and the set-flags gate on `carry_upd`. The other behaviours are shown only by the bench scenarios, which compare results against a reference model. These are the bit that feeds the carry for each shift kind, the immediate-zero reinterpretations (shift by 32 and rotate through carry), the program-counter source, the modulo behaviour of register rotates, and the masking of the amount register to 8 bits. The scenarios use amounts 0, 1, 31, 32, 33, 64 and 255, plus random fields.

// File: rtl/shift_operand_pkg.sv
// Shared types for the shifted register operand unit.
// Assumes a two-bit shift-kind field whose encoding the instruction decoder fixes.
package shift_operand_pkg;
    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/shift_field_decode.sv
// Decodes the operand field into a shift kind and an effective amount.
// It also flags the immediate-zero special cases.
// Assumes: DATA_W is a power of two and fits in an RS_AMT_W-bit amount.
module shift_field_decode
    import shift_operand_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RS_AMT_W = 8,
    parameter int PC_REG   = 15
) (
    input  logic [11:0]         op_field,
    input  logic [DATA_W-1:0]   rs_val,
    output shift_kind_e         kind,
    output logic [RS_AMT_W-1:0] amt,
    output logic                zero_amt,
    output logic                rrx,
    output logic                rm_is_pc
);
    localparam int IMM_W = $clog2(DATA_W);
    localparam int IMM_LO = 7;

    logic                by_reg;
    logic [IMM_W-1:0]    imm;
    logic [RS_AMT_W-1:0] reg_amt;

    assign by_reg   = op_field[4];
    assign kind     = shift_kind_e'(op_field[6:5]);
    assign imm      = op_field[IMM_LO +: IMM_W];
    assign reg_amt  = rs_val[RS_AMT_W-1:0];
    assign rm_is_pc = (op_field[3:0] == 4'(PC_REG));

    // Pick the effective amount and mark the amount-zero and rotate-through-carry cases
    always_comb begin
        if (by_reg) begin
            amt      = reg_amt;
            zero_amt = (reg_amt == '0);
            rrx      = 1'b0;
        end else begin
            zero_amt = (imm == '0) && (kind == SH_LSL);
            rrx      = (imm == '0) && (kind == SH_ROR);
            if ((imm == '0) && ((kind == SH_LSR) || (kind == SH_ASR)))
                amt = RS_AMT_W'(DATA_W);
            else
                amt = RS_AMT_W'(imm);
        end
    end
endmodule

// File: rtl/shift_core.sv
// Combinational shifter that yields the result, the carry, and whether the carry is affected.
// Assumes: amt is nonzero unless zero_amt or rrx is set; DATA_W is a power of two.
module shift_core
    import shift_operand_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RS_AMT_W = 8
) (
    input  logic [DATA_W-1:0]   x,
    input  shift_kind_e         kind,
    input  logic [RS_AMT_W-1:0] amt,
    input  logic                zero_amt,
    input  logic                rrx,
    input  logic                cin,
    output logic [DATA_W-1:0]   res,
    output logic                cout,
    output logic                affects
);
    localparam int ROT_W = $clog2(DATA_W);

    logic [DATA_W:0]     ext_l;
    logic [DATA_W:0]     ext_r;
    logic [DATA_W:0]     ext_a;
    logic [2*DATA_W-1:0] dbl;
    logic [RS_AMT_W-1:0] amt_clamp;

    // The extra bit next to the word catches the last bit shifted out, which becomes the carry
    assign ext_l     = {1'b0, x} << amt;
    assign ext_r     = {x, 1'b0} >> amt;
    assign amt_clamp = (amt > RS_AMT_W'(DATA_W)) ? RS_AMT_W'(DATA_W) : amt;
    assign ext_a     = $signed({x, 1'b0}) >>> amt_clamp;
    assign dbl       = {x, x} >> amt[ROT_W-1:0];

    // Select the result and the carry for the decoded shift
    always_comb begin
        affects = 1'b1;
        if (zero_amt) begin
            res     = x;
            cout    = cin;
            affects = 1'b0;
        end else if (rrx) begin
            res  = {cin, x[DATA_W-1:1]};
            cout = x[0];
        end else begin
            unique case (kind)
                SH_LSL: begin res = ext_l[DATA_W-1:0]; cout = ext_l[DATA_W]; end
                SH_LSR: begin res = ext_r[DATA_W:1];   cout = ext_r[0];      end
                SH_ASR: begin res = ext_a[DATA_W:1];   cout = ext_a[0];      end
                default: begin res = dbl[DATA_W-1:0];  cout = dbl[DATA_W-1]; end
            endcase
        end
    end
endmodule

// File: rtl/shift_operand_unit.sv
// Top level: selects the source value (program counter plus offset, or the register),
// decodes the field, shifts the value, and registers the result with one-cycle latency.
// Assumes: the caller supplies the register file reads for the named registers.
module shift_operand_unit
    import shift_operand_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RS_AMT_W  = 8,
    parameter int PC_REG    = 15,
    parameter int PC_OFFSET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [11:0]       op_field,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] instr_addr,
    input  logic              carry_in,
    input  logic              set_flags,
    output logic              out_valid,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out,
    output logic              carry_upd
);
    shift_kind_e         kind;
    logic [RS_AMT_W-1:0] amt;
    logic                zero_amt;
    logic                rrx;
    logic                rm_is_pc;
    logic [DATA_W-1:0]   src;
    logic [DATA_W-1:0]   core_res;
    logic                core_c;
    logic                core_aff;

    shift_field_decode #(.DATA_W(DATA_W), .RS_AMT_W(RS_AMT_W), .PC_REG(PC_REG)) u_dec (
        .op_field (op_field),
        .rs_val   (rs_val),
        .kind     (kind),
        .amt      (amt),
        .zero_amt (zero_amt),
        .rrx      (rrx),
        .rm_is_pc (rm_is_pc)
    );

    // Source operand: the register value, or the instruction address plus the offset
    assign src = rm_is_pc ? (instr_addr + DATA_W'(PC_OFFSET)) : rm_val;

    shift_core #(.DATA_W(DATA_W), .RS_AMT_W(RS_AMT_W)) u_core (
        .x        (src),
        .kind     (kind),
        .amt      (amt),
        .zero_amt (zero_amt),
        .rrx      (rrx),
        .cin      (carry_in),
        .res      (core_res),
        .cout     (core_c),
        .affects  (core_aff)
    );

    // Output register stage, cleared by synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            operand   <= '0;
            carry_out <= 1'b0;
            carry_upd <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                operand   <= core_res;
                carry_out <= core_c;
                carry_upd <= core_aff && set_flags;
            end else begin
                carry_upd <= 1'b0;
            end
        end
    end

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_zero_amount_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_field[4] && rs_val[RS_AMT_W-1:0] == '0) |=>
            (operand == $past(src) && !carry_upd && carry_out == $past(carry_in)));
    assert_over_range_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_field[4] && !op_field[6] && rs_val[RS_AMT_W-1:0] > RS_AMT_W'(DATA_W)) |=>
            (operand == '0 && !carry_out));
    assert_flag_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !set_flags) |=> !carry_upd);
endmodule

// File: tb/shift_operand_unit_tb.sv
module shift_operand_unit_tb;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] res;
        logic         c;
        logic         upd;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [11:0]  op_field = '0;
    logic [W-1:0] rm_val = '0;
    logic [W-1:0] rs_val = '0;
    logic [W-1:0] instr_addr = '0;
    logic         carry_in = 1'b0;
    logic         set_flags = 1'b0;
    logic         out_valid;
    logic [W-1:0] operand;
    logic         carry_out;
    logic         carry_upd;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #2 clk = ~clk;

    shift_operand_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_field(op_field),
        .rm_val(rm_val), .rs_val(rs_val), .instr_addr(instr_addr),
        .carry_in(carry_in), .set_flags(set_flags), .out_valid(out_valid),
        .operand(operand), .carry_out(carry_out), .carry_upd(carry_upd)
    );

    function automatic logic [11:0] f_imm(int kind, int n, int rm);
        return {5'(n), 2'(kind), 1'b0, 4'(rm)};
    endfunction

    function automatic logic [11:0] f_reg(int kind, int rs, int rm);
        return {4'(rs), 1'b0, 2'(kind), 1'b1, 4'(rm)};
    endfunction

    // Reference model written from the requirements
    function automatic item_t model(logic [11:0] op, logic [W-1:0] rm, logic [W-1:0] rs,
                                    logic [W-1:0] pc, logic cin, logic sf);
        item_t it;
        logic [W-1:0] x;
        int kind, n, a, r;
        bit aff;
        x = (op[3:0] == 4'd15) ? pc + 32'd8 : rm;
        kind = int'(op[6:5]);
        aff = 1'b1;
        it.c = cin;
        if (!op[4]) begin
            n = int'(op[11:7]);
            case (kind)
                0: if (n == 0) begin it.res = x; aff = 1'b0; end
                   else begin it.res = x << n; it.c = x[32-n]; end
                1: if (n == 0) begin it.res = '0; it.c = x[31]; end
                   else begin it.res = x >> n; it.c = x[n-1]; end
                2: if (n == 0) begin it.res = {W{x[31]}}; it.c = x[31]; end
                   else begin it.res = W'($signed(x) >>> n); it.c = x[n-1]; end
                default: if (n == 0) begin it.res = {cin, x[31:1]}; it.c = x[0]; end
                   else begin it.res = (x >> n) | (x << (32 - n)); it.c = x[n-1]; end
            endcase
        end else begin
            a = int'(rs[7:0]);
            if (a == 0) begin
                it.res = x; aff = 1'b0;
            end else begin
                case (kind)
                    0: if (a < 32) begin it.res = x << a; it.c = x[32-a]; end
                       else if (a == 32) begin it.res = '0; it.c = x[0]; end
                       else begin it.res = '0; it.c = 1'b0; end
                    1: if (a < 32) begin it.res = x >> a; it.c = x[a-1]; end
                       else if (a == 32) begin it.res = '0; it.c = x[31]; end
                       else begin it.res = '0; it.c = 1'b0; end
                    2: if (a >= 32) begin it.res = {W{x[31]}}; it.c = x[31]; end
                       else begin it.res = W'($signed(x) >>> a); it.c = x[a-1]; end
                    default: begin
                        r = a % 32;
                        it.res = (r == 0) ? x : ((x >> r) | (x << (32 - r)));
                        it.c = x[(a - 1) % 32];
                    end
                endcase
            end
        end
        it.upd = sf && aff;
        return it;
    endfunction

    // Driver: applies one request and queues the expected result
    task automatic send(logic [11:0] op, logic [W-1:0] rm, logic [W-1:0] rs,
                        logic [W-1:0] pc, logic cin, logic sf, string req);
        item_t it;
        @(negedge clk);
        op_field = op; rm_val = rm; rs_val = rs; instr_addr = pc;
        carry_in = cin; set_flags = sf; in_valid = 1'b1;
        it = model(op, rm, rs, pc, cin, sf);
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops and compares each result just after the edge that registers it
    always begin
        @(posedge clk);
        #1;
        if (rst_n && out_valid) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_errors++;
                $display("FAIL R1: unexpected out_valid, actual=1 expected=0");
            end else begin
                item_t e;
                e = sb.pop_front();
                if (operand !== e.res || carry_out !== e.c || carry_upd !== e.upd) begin
                    n_errors++;
                    $display("FAIL %s: actual op=%h c=%b upd=%b expected op=%h c=%b upd=%b",
                             e.req, operand, carry_out, carry_upd, e.res, e.c, e.upd);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || carry_upd !== 1'b0) begin
            n_errors++;
            $display("FAIL R12: actual valid=%b upd=%b expected 0 0", out_valid, carry_upd);
        end
        rst_n = 1'b1;
        idle(2);

        // R3 immediate left shifts
        send(f_imm(0, 0, 1), 32'h8000_0001, 0, 0, 1'b1, 1'b1, "R3");
        send(f_imm(0, 1, 1), 32'h8000_0001, 0, 0, 1'b0, 1'b1, "R3");
        send(f_imm(0, 31, 1), 32'h0000_0003, 0, 0, 1'b0, 1'b1, "R3");
        // R4 immediate zero as 32, and ordinary right shifts
        send(f_imm(1, 0, 2), 32'h8000_0001, 0, 0, 1'b0, 1'b1, "R4");
        send(f_imm(2, 0, 2), 32'h8000_0000, 0, 0, 1'b0, 1'b1, "R4");
        send(f_imm(2, 0, 2), 32'h7FFF_FFFF, 0, 0, 1'b1, 1'b1, "R4");
        send(f_imm(1, 4, 2), 32'hF000_000F, 0, 0, 1'b0, 1'b1, "R4");
        send(f_imm(2, 31, 2), 32'h8000_0000, 0, 0, 1'b0, 1'b1, "R4");
        // R5 rotate through carry and immediate rotate
        send(f_imm(3, 0, 3), 32'h0000_0003, 0, 0, 1'b1, 1'b1, "R5");
        send(f_imm(3, 0, 3), 32'h0000_0002, 0, 0, 1'b0, 1'b1, "R5");
        send(f_imm(3, 8, 3), 32'h1234_5680, 0, 0, 1'b0, 1'b1, "R5");
        // R6 register amount zero for every kind
        for (int k = 0; k < 4; k++)
            send(f_reg(k, 4, 5), 32'hDEAD_BEEF, 32'h0, 0, 1'b1, 1'b1, "R6");
        // R7 register LSL/LSR range edges
        send(f_reg(0, 4, 5), 32'h0000_0001, 32, 0, 1'b0, 1'b1, "R7");
        send(f_reg(0, 4, 5), 32'hFFFF_FFFF, 33, 0, 1'b1, 1'b1, "R7");
        send(f_reg(0, 4, 5), 32'hFFFF_FFFF, 255, 0, 1'b1, 1'b1, "R7");
        send(f_reg(0, 4, 5), 32'h0000_0003, 31, 0, 1'b0, 1'b1, "R7");
        send(f_reg(1, 4, 5), 32'h8000_0000, 32, 0, 1'b0, 1'b1, "R7");
        send(f_reg(1, 4, 5), 32'hFFFF_FFFF, 33, 0, 1'b1, 1'b1, "R7");
        send(f_reg(1, 4, 5), 32'h0000_0003, 1, 0, 1'b0, 1'b1, "R7");
        // R8 register ASR range edges
        send(f_reg(2, 4, 5), 32'h8000_0000, 32, 0, 1'b0, 1'b1, "R8");
        send(f_reg(2, 4, 5), 32'h8000_0000, 255, 0, 1'b0, 1'b1, "R8");
        send(f_reg(2, 4, 5), 32'h7000_0000, 33, 0, 1'b1, 1'b1, "R8");
        send(f_reg(2, 4, 5), 32'hC000_0000, 31, 0, 1'b0, 1'b1, "R8");
        // R9 register rotates with modulo amounts
        send(f_reg(3, 4, 5), 32'h8000_0001, 32, 0, 1'b0, 1'b1, "R9");
        send(f_reg(3, 4, 5), 32'h8000_0002, 33, 0, 1'b0, 1'b1, "R9");
        send(f_reg(3, 4, 5), 32'h0000_0001, 64, 0, 1'b1, 1'b1, "R9");
        send(f_reg(3, 4, 5), 32'h0000_0001, 1, 0, 1'b0, 1'b1, "R9");
        send(f_reg(3, 4, 5), 32'h4000_0000, 31, 0, 1'b0, 1'b1, "R9");
        // R2 program-counter source
        send(f_imm(0, 0, 15), 32'h1111_1111, 0, 32'h0000_1000, 1'b0, 1'b1, "R2");
        send(f_imm(1, 4, 15), 32'h1111_1111, 0, 32'hFFFF_FFFC, 1'b0, 1'b1, "R2");
        // R10 flag gate with set_flags low
        send(f_imm(0, 1, 1), 32'h8000_0000, 0, 0, 1'b0, 1'b0, "R10");
        send(f_imm(3, 0, 1), 32'h0000_0001, 0, 0, 1'b0, 1'b0, "R10");
        // R11 upper bits of the amount register ignored
        send(f_reg(0, 4, 5), 32'h0000_0001, 32'hFFFF_FF00, 0, 1'b1, 1'b1, "R11");
        send(f_reg(1, 4, 5), 32'h0000_0010, 32'hABCD_0104, 0, 1'b0, 1'b1, "R11");
        idle(3);
        // R1 back-to-back and gapped random traffic
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] amtv;
            amtv = (i % 3 == 0) ? $urandom : W'($urandom_range(0, 40));
            send(12'($urandom), $urandom, amtv, $urandom, 1'($urandom), 1'($urandom), "R1");
            if (i % 7 == 0) idle(1);
        end
        idle(4);
        n_checks++;
        if (sb.size() != 0) begin
            n_errors++;
            $display("FAIL R1: pending results actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule